// File: doc/BRIEF.md
# Adaptive On-Time Gate Pulse Sequencer

This block is the digital timing core of an adaptive on-time step-down controller. A comparator output from the analog loop tells the block that the current feedback has fallen to the error level. That edge becomes one request for a high-side on pulse. The pulse length is set so that the switching period stays nearly constant. It is computed from digitized input and output voltage codes and from the switching period chosen by the mode input. The period is about 700 kHz with `fast_sel_i` low and 1 MHz with it high, counted in clock cycles.

Around each pulse the block applies several timing rules. It keeps a minimum off time after every pulse and holds off a new pulse while the valley current comparator reports over-current. Between the two gate commands it inserts one dead clock. In skip mode it turns the low-side gate off at the zero crossing of the inductor current. In forced-PWM mode it ignores the zero-cross comparator, and a negative over-current indication starts the next on pulse. Removing enable parks both gates low.

Top module: `aot_pwm_ctrl`

## Requirements
- R1: The high-side pulse lasts T clocks, where P is CLK_PER_FAST when `fast_sel_i`=1 and CLK_PER_SLOW when 0. T = P when `vin_code_i`=0 or `vout_code_i`>=`vin_code_i`; otherwise T = floor(`vout_code_i`*P/`vin_code_i`), raised to 1 if that is 0.
- R2: The on-time is captured when the pulse starts; changing the voltage codes during a pulse does not change its length.
- R3: A rising edge on `pwm_cmp_i` creates one pending request. When nothing blocks the request, `hs_gate_o` rises at the second clock edge after the edge that first samples `pwm_cmp_i` high. A level held high yields one pulse, and a rising edge that arrives while a pulse is being started or is running is dropped.
- R4: Between two high-side pulses `hs_gate_o` stays low for at least MIN_OFF_CYC clocks. A request raised just after a pulse ends is served after exactly MIN_OFF_CYC low clocks.
- R5: While `ocl_pos_i` is high no pulse starts, and the request is kept. The pulse starts on the second edge after `ocl_pos_i` is sampled low.
- R6: In skip mode (`fpwm_i`=0), `zc_i` high while the low side is on turns `ls_gate_o` off at the next edge. Both gates then stay low until the next pulse.
- R7: In forced-PWM mode (`fpwm_i`=1) `zc_i` has no effect and the low side stays on.
- R8: In forced-PWM mode, `ocl_neg_i` high while the low side is on starts an on pulse without any comparator request, subject to R4 and R5. In skip mode `ocl_neg_i` is ignored.
- R9: The two gates are never high together, and each switch from one gate to the other passes through at least one clock with both low.
- R10: With `en_i` low both gates are low from the next edge and any pending request is discarded.
- R11: During and after reset both gates are low. The first request after reset is not delayed by the off-time rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable |
| fast_sel_i | input | 1 | Switching period select: 1 = fast, 0 = slow |
| fpwm_i | input | 1 | 1 = forced PWM, 0 = skip mode |
| pwm_cmp_i | input | 1 | Loop comparator: current feedback reached error level |
| ocl_pos_i | input | 1 | Valley current above positive limit |
| ocl_neg_i | input | 1 | Current beyond negative limit |
| zc_i | input | 1 | Inductor current zero crossing |
| vin_code_i | input | CODE_W | Input voltage code |
| vout_code_i | input | CODE_W | Output voltage code |
| hs_gate_o | output | 1 | High-side gate command |
| ls_gate_o | output | 1 | Low-side gate command |

## Verification
Two events can meet in one cycle: a start decision can land on the very edge where a low-side exit condition is also true. Zero crossing or a negative over-current indication can coincide with a pending request that has just cleared the off-time and over-current gates. The bench provokes this by raising the comparator right after a pulse ends, so the request becomes due on a counted edge. It also holds the over-current comparator and releases it at a known edge. It judges the outcome from the exact number of low clocks before the next pulse, the two-edge start latency, and a per-cycle watch on both gates for overlap or missing dead time.

// File: rtl/aot_pkg.sv
package aot_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_DT_H = 3'd1,
    ST_HS   = 3'd2,
    ST_DT_L = 3'd3,
    ST_LS   = 3'd4
  } gate_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/aot_ontime_calc.sv
module aot_ontime_calc #(
  parameter int CODE_W        = 8,
  parameter int CLK_PER_FAST  = 100,
  parameter int CLK_PER_SLOW  = 143,
  parameter int PER_W         = 8
) (
  input  logic [CODE_W-1:0] vin_code_i,
  input  logic [CODE_W-1:0] vout_code_i,
  input  logic              fast_sel_i,
  output logic [PER_W-1:0]  ton_cyc_o
);
  localparam int PROD_W = CODE_W + PER_W;

  logic [PER_W-1:0]  period;
  logic [PROD_W-1:0] prod, divisor, quo;
  logic              saturate;

  assign period   = fast_sel_i ? PER_W'(CLK_PER_FAST) : PER_W'(CLK_PER_SLOW);
  assign saturate = (vin_code_i == '0) || (vout_code_i >= vin_code_i);
  assign prod     = PROD_W'(vout_code_i) * PROD_W'(period);
  assign divisor  = (vin_code_i == '0) ? PROD_W'(1) : PROD_W'(vin_code_i);
  assign quo      = prod / divisor;

  always_comb begin
    if (saturate)        ton_cyc_o = period;
    else if (quo == '0)  ton_cyc_o = PER_W'(1);
    else                 ton_cyc_o = quo[PER_W-1:0];
  end
endmodule

// File: rtl/aot_req_latch.sv
module aot_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cmp_i,
  input  logic accept_i,
  input  logic take_i,
  output logic pending_o
);
  logic cmp_q;
  logic rise;

  assign rise = cmp_i & ~cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q     <= 1'b0;
      pending_o <= 1'b0;
    end else begin
      cmp_q <= cmp_i;
      if (!en_i || take_i)       pending_o <= 1'b0;
      else if (rise && accept_i) pending_o <= 1'b1;
    end
  end

  // a dropped edge (no accept) must never create a request
  AST_NO_STRAY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_o && !accept_i) |=> !pending_o) else $error("stray request"); // R3
endmodule

// File: rtl/aot_gate_seq.sv
module aot_gate_seq
  import aot_pkg::*;
#(
  parameter int PER_W       = 8,
  parameter int MIN_OFF_CYC = 36
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fpwm_i,
  input  logic             pending_i,
  input  logic             ocl_pos_i,
  input  logic             ocl_neg_i,
  input  logic             zc_i,
  input  logic [PER_W-1:0] ton_cyc_i,
  output logic             take_o,
  output logic             accept_o,
  output logic             hs_o,
  output logic             ls_o
);
  localparam int OFF_W  = $clog2(MIN_OFF_CYC + 1);
  localparam int OFF_GO = MIN_OFF_CYC - 2;

  gate_state_e      state_q, state_d;
  logic [PER_W-1:0] ton_cnt_q;
  logic [OFF_W-1:0] off_cnt_q;
  logic             idle_st, off_ok, neg_kick, can_start;

  assign idle_st   = (state_q == ST_LS) || (state_q == ST_OFF);
  assign off_ok    = off_cnt_q >= OFF_W'(OFF_GO);
  assign neg_kick  = fpwm_i && ocl_neg_i && (state_q == ST_LS);
  assign can_start = idle_st && off_ok && !ocl_pos_i && (pending_i || neg_kick);
  assign take_o    = en_i && can_start;
  assign accept_o  = (state_q != ST_DT_H) && (state_q != ST_HS);
  assign hs_o      = (state_q == ST_HS);
  assign ls_o      = (state_q == ST_LS);

  always_comb begin
    state_d = state_q;
    if (!en_i) state_d = ST_OFF;
    else begin
      case (state_q)
        ST_OFF:  if (can_start) state_d = ST_DT_H;
        ST_DT_H: state_d = ST_HS;
        ST_HS:   if (ton_cnt_q <= PER_W'(1)) state_d = ST_DT_L;
        ST_DT_L: state_d = ST_LS;
        ST_LS: begin
          if (can_start)            state_d = ST_DT_H;
          else if (!fpwm_i && zc_i) state_d = ST_OFF;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OFF;
      ton_cnt_q <= '0;
      off_cnt_q <= OFF_W'(MIN_OFF_CYC);
    end else begin
      state_q <= state_d;
      if (state_q == ST_DT_H)   ton_cnt_q <= ton_cyc_i;
      else if (state_q == ST_HS) ton_cnt_q <= ton_cnt_q - PER_W'(1);
      if (state_q == ST_HS)                       off_cnt_q <= '0;
      else if (off_cnt_q < OFF_W'(MIN_OFF_CYC))   off_cnt_q <= off_cnt_q + OFF_W'(1);
    end
  end

  initial begin
    if (MIN_OFF_CYC < 3) $error("MIN_OFF_CYC must be at least 3");
  end

  AST_DEAD_LS_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_o |=> !hs_o) else $error("no dead time low->high"); // R9
  AST_DEAD_HS_LS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_o |=> !ls_o) else $error("no dead time high->low"); // R9
  AST_DISABLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!hs_o && !ls_o)) else $error("gate on while disabled"); // R10
  AST_MIN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> (off_cnt_q >= OFF_W'(MIN_OFF_CYC - 1))) else $error("off time short"); // R4
  AST_OCL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> !$past(ocl_pos_i, 2)) else $error("pulse under over-current"); // R5
  AST_TON_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_o && $past(hs_o)) |-> (ton_cnt_q == $past(ton_cnt_q) - PER_W'(1))) else $error("on-time disturbed"); // R2
  AST_ZC_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fpwm_i && zc_i && ls_o) |=> !ls_o) else $error("low side kept past zero cross"); // R6
endmodule

// File: rtl/aot_pwm_ctrl.sv
module aot_pwm_ctrl #(
  parameter int CODE_W       = 8,
  parameter int CLK_PER_FAST = 100,
  parameter int CLK_PER_SLOW = 143,
  parameter int MIN_OFF_CYC  = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fast_sel_i,
  input  logic              fpwm_i,
  input  logic              pwm_cmp_i,
  input  logic              ocl_pos_i,
  input  logic              ocl_neg_i,
  input  logic              zc_i,
  input  logic [CODE_W-1:0] vin_code_i,
  input  logic [CODE_W-1:0] vout_code_i,
  output logic              hs_gate_o,
  output logic              ls_gate_o
);
  localparam int PER_MAX = aot_pkg::max_int(CLK_PER_FAST, CLK_PER_SLOW);
  localparam int PER_W   = $clog2(PER_MAX + 1);

  logic [PER_W-1:0] ton_cyc;
  logic             pending, take, accept;

  aot_ontime_calc #(
    .CODE_W(CODE_W), .CLK_PER_FAST(CLK_PER_FAST),
    .CLK_PER_SLOW(CLK_PER_SLOW), .PER_W(PER_W)
  ) u_ontime (
    .vin_code_i (vin_code_i),
    .vout_code_i(vout_code_i),
    .fast_sel_i (fast_sel_i),
    .ton_cyc_o  (ton_cyc)
  );

  aot_req_latch u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .cmp_i    (pwm_cmp_i),
    .accept_i (accept),
    .take_i   (take),
    .pending_o(pending)
  );

  aot_gate_seq #(.PER_W(PER_W), .MIN_OFF_CYC(MIN_OFF_CYC)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .fpwm_i   (fpwm_i),
    .pending_i(pending),
    .ocl_pos_i(ocl_pos_i),
    .ocl_neg_i(ocl_neg_i),
    .zc_i     (zc_i),
    .ton_cyc_i(ton_cyc),
    .take_o   (take),
    .accept_o (accept),
    .hs_o     (hs_gate_o),
    .ls_o     (ls_gate_o)
  );
endmodule

// File: tb/tb_aot_pwm_ctrl.sv
module tb_aot_pwm_ctrl;
  localparam int MIN_OFF = 36;
  localparam int PFAST   = 100;
  localparam int PSLOW   = 143;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, fast_sel_i = 1'b1, fpwm_i = 1'b0, pwm_cmp_i = 1'b0;
  logic ocl_pos_i = 1'b0, ocl_neg_i = 1'b0, zc_i = 1'b0;
  logic [7:0] vin_code_i = 8'd200, vout_code_i = 8'd100;
  logic hs_gate_o, ls_gate_o;

  int checks = 0, failures = 0, pulses = 0, ovl_err = 0, dead_err = 0;
  bit prev_hs = 0, prev_ls = 0, done = 0;

  aot_pwm_ctrl #(.CODE_W(8), .CLK_PER_FAST(PFAST), .CLK_PER_SLOW(PSLOW),
                 .MIN_OFF_CYC(MIN_OFF)) dut (.*);

  always #5 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (hs_gate_o && ls_gate_o) ovl_err++;
      if (hs_gate_o && prev_ls) dead_err++;
      if (ls_gate_o && prev_hs) dead_err++;
      if (hs_gate_o && !prev_hs) pulses++;
    end
    prev_hs = hs_gate_o;
    prev_ls = ls_gate_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ton(input int vi, input int vo, input bit f);
    int p, q;
    p = f ? PFAST : PSLOW;
    if (vi == 0 || vo >= vi) return p;
    q = vo * p / vi;
    return (q < 1) ? 1 : q;
  endfunction

  // comparator pulse of one clock, then latency and width of the resulting pulse
  task automatic fire_measure(output int lat, output int width);
    @(negedge clk_i); pwm_cmp_i = 1'b1;
    @(negedge clk_i); pwm_cmp_i = 1'b0;
    lat = 1;
    while (!hs_gate_o && lat < 500) begin @(negedge clk_i); lat++; end
    width = 0;
    while (hs_gate_o && width < 1000) begin width++; @(negedge clk_i); end
  endtask

  task automatic settle();
    repeat (MIN_OFF + 4) @(negedge clk_i);
  endtask

  initial begin
    int lat, w, g, p0;
    repeat (3) @(negedge clk_i);
    chk(!hs_gate_o && !ls_gate_o, "R11 reset", {hs_gate_o, ls_gate_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(!hs_gate_o && !ls_gate_o, "R11 after reset", {hs_gate_o, ls_gate_o}, 0);
    en_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!hs_gate_o && !ls_gate_o, "R10 enabled idle", {hs_gate_o, ls_gate_o}, 0);

    fire_measure(lat, w);
    chk(lat == 3, "R11 first request latency", lat, 3);
    chk(w == 50, "R1 first width", w, 50);
    settle();

    // R1 / R3 sweep over codes and both periods
    for (int f = 0; f < 2; f++) begin
      for (int vi = 0; vi < 256; vi += 51) begin
        for (int vo = 0; vo < 256; vo += 51) begin
          fast_sel_i = f[0]; vin_code_i = 8'(vi); vout_code_i = 8'(vo);
          fire_measure(lat, w);
          chk(w == exp_ton(vi, vo, f[0]), "R1 width sweep", w, exp_ton(vi, vo, f[0]));
          chk(lat == 3, "R3 start latency", lat, 3);
          settle();
        end
      end
    end
    vin_code_i = 8'd3; vout_code_i = 8'd1; fast_sel_i = 1'b1;
    fire_measure(lat, w);
    chk(w == 33, "R1 small ratio", w, 33);
    settle();

    // R2: codes changed mid-pulse
    vin_code_i = 8'd100; vout_code_i = 8'd50;
    @(negedge clk_i); pwm_cmp_i = 1'b1;
    @(negedge clk_i); pwm_cmp_i = 1'b0;
    while (!hs_gate_o) @(negedge clk_i);
    vout_code_i = 8'd10; fast_sel_i = 1'b0;
    w = 0;
    while (hs_gate_o && w < 1000) begin w++; @(negedge clk_i); end
    chk(w == 50, "R2 latched on-time", w, 50);
    fast_sel_i = 1'b1; vout_code_i = 8'd50;

    // R4: request right after pulse end is served after exactly MIN_OFF low clocks
    g = 1; pwm_cmp_i = 1'b1;
    @(negedge clk_i); pwm_cmp_i = 1'b0;
    while (!hs_gate_o && g < 1000) begin g++; @(negedge clk_i); end
    chk(g == MIN_OFF, "R4 min off gap", g, MIN_OFF);
    while (hs_gate_o) @(negedge clk_i);
    settle();

    // R3: held level gives one pulse; edge during pulse dropped
    p0 = pulses;
    @(negedge clk_i); pwm_cmp_i = 1'b1;
    repeat (300) @(negedge clk_i);
    pwm_cmp_i = 1'b0;
    settle();
    chk(pulses - p0 == 1, "R3 held level", pulses - p0, 1);
    p0 = pulses;
    @(negedge clk_i); pwm_cmp_i = 1'b1;
    @(negedge clk_i); pwm_cmp_i = 1'b0;
    while (!hs_gate_o) @(negedge clk_i);
    repeat (5) @(negedge clk_i);
    pwm_cmp_i = 1'b1;
    @(negedge clk_i); pwm_cmp_i = 1'b0;
    repeat (200) @(negedge clk_i);
    chk(pulses - p0 == 1, "R3 edge during pulse", pulses - p0, 1);

    // R5: over-current hold-off
    p0 = pulses;
    ocl_pos_i = 1'b1;
    @(negedge clk_i); pwm_cmp_i = 1'b1;
    @(negedge clk_i); pwm_cmp_i = 1'b0;
    repeat (100) @(negedge clk_i);
    chk(pulses == p0, "R5 held under OCL", pulses - p0, 0);
    ocl_pos_i = 1'b0;
    @(negedge clk_i);
    chk(!hs_gate_o, "R5 release first edge", hs_gate_o, 0);
    @(negedge clk_i);
    chk(hs_gate_o, "R5 release second edge", hs_gate_o, 1);
    while (hs_gate_o) @(negedge clk_i);
    settle();

    // R6: skip mode zero crossing
    chk(ls_gate_o, "R6 low side on before zc", ls_gate_o, 1);
    zc_i = 1'b1;
    @(negedge clk_i);
    chk(!ls_gate_o, "R6 zc cut", ls_gate_o, 0);
    zc_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk(!ls_gate_o && !hs_gate_o, "R6 stays off", {hs_gate_o, ls_gate_o}, 0);
    fire_measure(lat, w);
    chk(lat == 3 && w == 50, "R6 restart from off", lat, 3);
    settle();

    // R7: forced PWM ignores zc
    fpwm_i = 1'b1;
    zc_i = 1'b1;
    repeat (20) @(negedge clk_i);
    chk(ls_gate_o, "R7 zc ignored", ls_gate_o, 1);
    zc_i = 1'b0;

    // R8: negative OCL kicks a pulse in forced PWM only
    ocl_neg_i = 1'b1;
    @(negedge clk_i);
    chk(!hs_gate_o, "R8 neg kick first edge", hs_gate_o, 0);
    @(negedge clk_i);
    chk(hs_gate_o, "R8 neg kick pulse", hs_gate_o, 1);
    ocl_neg_i = 1'b0;
    while (hs_gate_o) @(negedge clk_i);
    settle();
    fpwm_i = 1'b0;
    p0 = pulses;
    ocl_neg_i = 1'b1;
    repeat (100) @(negedge clk_i);
    ocl_neg_i = 1'b0;
    chk(pulses == p0 && ls_gate_o, "R8 ignored in skip", pulses - p0, 0);

    // R10: disable mid-pulse, pending discarded
    @(negedge clk_i); pwm_cmp_i = 1'b1;
    @(negedge clk_i); pwm_cmp_i = 1'b0;
    while (!hs_gate_o) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk(!hs_gate_o && !ls_gate_o, "R10 disable mid pulse", {hs_gate_o, ls_gate_o}, 0);
    en_i = 1'b1;
    settle();
    p0 = pulses;
    ocl_pos_i = 1'b1;
    @(negedge clk_i); pwm_cmp_i = 1'b1;
    @(negedge clk_i); pwm_cmp_i = 1'b0;
    repeat (3) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    ocl_pos_i = 1'b0;
    en_i = 1'b1;
    repeat (60) @(negedge clk_i);
    chk(pulses == p0 && !hs_gate_o, "R10 pending dropped", pulses - p0, 0);

    chk(ovl_err == 0, "R9 overlap", ovl_err, 0);
    chk(dead_err == 0, "R9 dead time", dead_err, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule